// File: doc/BRIEF.md
# Static Memory Area Controller

This block sits between a processor and up to four static memory regions. It decodes each processor address into one area. It drives one active-low chip select per area and sequences the external cycle: a setup cycle, a programmable access phase and an off-bus recovery phase. During the access phase it drives an active-low output enable or per-lane active-low write strobes.

Each area has its own configuration word on a simple register bus. The word holds the access wait count, the recovery wait count, a wait-source select, a write-protect flag, a narrow-write permission flag and a device width code. A system control bit exchanges the lowest area with the fourth area, so that the fast internal RAM can appear at address zero.

Illegal writes still complete on the bus but produce no strobe and raise an error flag alongside the ready pulse. These are writes to a protected area and narrow writes that the area forbids.

Top module: `smc_top`

## Requirements
- R1: Address bits 31:29 choose the area: 000 to 011 select areas 0 to 3, whose chip selects are `mem_cs_no[0]` to `mem_cs_no[3]`. A request to any other value gets `ready_o` and `err_o` high in the same cycle as the request, and no chip select is driven.
- R2: The configuration words of areas 0..3 are read and written at 0xE000_8000 + 4*area. Bits 23:8 always read zero. The reset value is 0xFF00_0035 for area 0 and 0xFF00_0034 for the others.
- R3: When bit 5 of the word is 1, an accepted request holds the chip select low for 1 setup cycle, then (bits 31:28 + 1) access cycles, then (bits 27:24) recovery cycles. `ready_o` is high for exactly the last access cycle.
- R4: When bit 5 is 0, the access phase lasts while `ext_wait_ni` is low and ends in the first access cycle in which it is high. When bit 5 is 1, `ext_wait_ni` has no effect.
- R5: A write to an area whose bit 4 is 1 drives no write strobe. It still completes, and `err_o` is high together with `ready_o`.
- R6: A write is narrow when `be_i` is 01 or 10 and the area's width code (bits 1:0) is 01 (16-bit) or 10 (32-bit). A narrow write to an area whose bit 3 is 0 drives no strobe and raises `err_o` with `ready_o`. Reads are never refused.
- R7: During the access phase only, a read drives `mem_oe_no` low, and a permitted write drives `mem_we_no[i]` low for each lane i with `be_i[i]` set. The output enable and the write strobes are never low together.
- R8: Bit 0 of the system control word at 0xE000_2004 swaps areas 0 and 3, including their chip selects and configuration words. Its other bits read zero.
- R9: The swap bit and the decode are taken only when a request is accepted in the idle state. A change during an access does not move it to another chip select, and at most one chip select is ever low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 1 | Register bus select |
| reg_we_i | input | 1 | Register bus write enable |
| reg_addr_i | input | 32 | Register bus address |
| reg_wdata_i | input | 32 | Register bus write data |
| reg_rdata_o | output | 32 | Register bus read data (combinational) |
| req_i | input | 1 | Processor access request, held until ready |
| addr_i | input | 32 | Processor address |
| wr_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 2 | Byte lane enables |
| ready_o | output | 1 | Access complete pulse |
| err_o | output | 1 | Access refused or unmapped, with ready |
| mem_cs_no | output | 4 | Per-area chip selects, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 2 | Per-lane write strobes, active low |
| mem_addr_o | output | 29 | Offset within the area |
| ext_wait_ni | input | 1 | External wait, active low |

## Verification
The bench times every access edge to edge, so an off-by-one in the access or recovery count moves the ready cycle or the chip-select length. It holds the external wait low in programmed mode and stretches it in external mode. A controller that listens to the wrong source would end early or hang. It drops the swap bit in the middle of a swapped access: a design that re-decodes on the fly would pulse a second chip select. Writes to protected areas and narrow writes to areas that forbid them must show no strobe at all, not a late or partial one, and must still return ready with the error flag.

// File: rtl/smc_pkg.sv
`timescale 1ns/1ps
package smc_pkg;
  localparam int CFG_W  = 32;
  localparam int WAIT_W = 4;
  localparam int DSZ_W  = 2;

  // configuration word field positions
  localparam int AW_LSB   = 28;
  localparam int RW_LSB   = 24;
  localparam int WSRC_BIT = 5;
  localparam int RO_BIT   = 4;
  localparam int SUBW_BIT = 3;
  localparam int DSZ_LSB  = 0;

  localparam logic [CFG_W-1:0] CFG_KEEP_MASK = 32'hFF00_00FF;
  localparam logic [CFG_W-1:0] CFG_RST_BOOT  = 32'hFF00_0035;
  localparam logic [CFG_W-1:0] CFG_RST_OTHER = 32'hFF00_0034;

  localparam logic [DSZ_W-1:0] DSZ_16 = 2'b01;
  localparam logic [DSZ_W-1:0] DSZ_32 = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_ACCESS  = 2'd2,
    ST_RECOVER = 2'd3
  } acc_state_e;
endpackage

// File: rtl/smc_cfg_regs.sv
`timescale 1ns/1ps
module smc_cfg_regs import smc_pkg::*; #(
  parameter int                N_AREAS  = 4,
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] CFG_BASE = 32'hE000_8000,
  parameter logic [ADDR_W-1:0] SCR_ADDR = 32'hE000_2004
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             reg_sel_i,
  input  logic                             reg_we_i,
  input  logic [ADDR_W-1:0]                reg_addr_i,
  input  logic [CFG_W-1:0]                 reg_wdata_i,
  output logic [CFG_W-1:0]                 reg_rdata_o,
  output logic [N_AREAS-1:0][WAIT_W-1:0]   acc_wait_o,
  output logic [N_AREAS-1:0][WAIT_W-1:0]   rec_wait_o,
  output logic [N_AREAS-1:0]               wait_prog_o,
  output logic [N_AREAS-1:0]               rd_only_o,
  output logic [N_AREAS-1:0]               sub_wr_o,
  output logic [N_AREAS-1:0][DSZ_W-1:0]    dsize_o,
  output logic                             swap_o
);
  logic [N_AREAS-1:0][CFG_W-1:0] cfg_q;
  logic [N_AREAS-1:0]            cfg_hit;
  logic                          scr_hit;
  logic                          wr_en;
  logic                          swap_q;

  assign wr_en   = reg_sel_i && reg_we_i;
  assign scr_hit = (reg_addr_i == SCR_ADDR);

  for (genvar g = 0; g < N_AREAS; g++) begin : g_area
    localparam logic [CFG_W-1:0] RST_V = (g == 0) ? CFG_RST_BOOT : CFG_RST_OTHER;
    logic [CFG_W-1:0] q;

    assign cfg_hit[g] = (reg_addr_i == CFG_BASE + ADDR_W'(4 * g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 q <= RST_V;
      else if (wr_en && cfg_hit[g]) q <= reg_wdata_i & CFG_KEEP_MASK;
    end

    assign cfg_q[g]       = q;
    assign acc_wait_o[g]  = q[AW_LSB +: WAIT_W];
    assign rec_wait_o[g]  = q[RW_LSB +: WAIT_W];
    assign wait_prog_o[g] = q[WSRC_BIT];
    assign rd_only_o[g]   = q[RO_BIT];
    assign sub_wr_o[g]    = q[SUBW_BIT];
    assign dsize_o[g]     = q[DSZ_LSB +: DSZ_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              swap_q <= 1'b0;
    else if (wr_en && scr_hit) swap_q <= reg_wdata_i[0];
  end

  assign swap_o = swap_q;

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < N_AREAS; i++) begin
      if (cfg_hit[i]) reg_rdata_o = cfg_q[i];
    end
    if (scr_hit) reg_rdata_o = {{(CFG_W-1){1'b0}}, swap_q};
  end
endmodule

// File: rtl/smc_area_decode.sv
`timescale 1ns/1ps
module smc_area_decode #(
  parameter int N_AREAS = 4,
  parameter int SEL_W   = 3,
  parameter int IDX_W   = 2
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             swap_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] area_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_AREAS - 1);

  logic [IDX_W-1:0] raw;
  assign raw = sel_i[IDX_W-1:0];

  if (N_AREAS == (1 << SEL_W)) begin : g_full
    assign hit_o = 1'b1;
  end else begin : g_part
    assign hit_o = (int'(sel_i) < N_AREAS);
  end

  // boot area and top area trade places while the swap bit is set
  always_comb begin
    area_o = raw;
    if (swap_i) begin
      if (raw == '0)       area_o = LAST;
      else if (raw == LAST) area_o = '0;
    end
  end
endmodule

// File: rtl/smc_access_fsm.sv
`timescale 1ns/1ps
module smc_access_fsm import smc_pkg::*; #(
  parameter int N_AREAS = 4,
  parameter int IDX_W   = 2,
  parameter int OFF_W   = 29,
  parameter int LANES   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               wr_i,
  input  logic [LANES-1:0]   be_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic               hit_i,
  input  logic [IDX_W-1:0]   area_i,
  input  logic [WAIT_W-1:0]  acc_wait_i,
  input  logic [WAIT_W-1:0]  rec_wait_i,
  input  logic               wait_prog_i,
  input  logic               rd_only_i,
  input  logic               sub_wr_i,
  input  logic [DSZ_W-1:0]   dsize_i,
  input  logic               ext_wait_ni,
  output logic               ready_o,
  output logic               err_o,
  output logic [N_AREAS-1:0] cs_no,
  output logic               oe_no,
  output logic [LANES-1:0]   we_no,
  output logic [OFF_W-1:0]   addr_o
);
  acc_state_e        st_q, st_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0]  area_q;
  logic [WAIT_W-1:0] acc_wait_q, rec_wait_q;
  logic              wait_prog_q;
  logic              wr_q, viol_q;
  logic [LANES-1:0]  be_q;
  logic [OFF_W-1:0]  off_q;

  logic accept, miss, narrow, viol_d, acc_done;

  assign accept = (st_q == ST_IDLE) && req_i && hit_i;
  assign miss   = (st_q == ST_IDLE) && req_i && !hit_i;

  assign narrow = (be_i != '1) && (be_i != '0) &&
                  ((dsize_i == DSZ_16) || (dsize_i == DSZ_32));
  assign viol_d = wr_i && (rd_only_i || (narrow && !sub_wr_i));

  assign acc_done = wait_prog_q ? (cnt_q == '0) : ext_wait_ni;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE:  if (accept) st_d = ST_SETUP;
      ST_SETUP: begin
        st_d  = ST_ACCESS;
        cnt_d = acc_wait_q;
      end
      ST_ACCESS: begin
        if (acc_done) begin
          if (rec_wait_q == '0) st_d = ST_IDLE;
          else begin
            st_d  = ST_RECOVER;
            cnt_d = rec_wait_q;
          end
        end else if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RECOVER: begin
        if (cnt_q <= WAIT_W'(1)) st_d = ST_IDLE;
        else                     cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // access attributes frozen at acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      area_q      <= '0;
      acc_wait_q  <= '0;
      rec_wait_q  <= '0;
      wait_prog_q <= 1'b1;
      wr_q        <= 1'b0;
      viol_q      <= 1'b0;
      be_q        <= '0;
      off_q       <= '0;
    end else if (accept) begin
      area_q      <= area_i;
      acc_wait_q  <= acc_wait_i;
      rec_wait_q  <= rec_wait_i;
      wait_prog_q <= wait_prog_i;
      wr_q        <= wr_i;
      viol_q      <= viol_d;
      be_q        <= be_i;
      off_q       <= off_i;
    end
  end

  logic in_acc, busy;
  assign in_acc = (st_q == ST_ACCESS);
  assign busy   = (st_q != ST_IDLE);

  assign ready_o = miss || (in_acc && acc_done);
  assign err_o   = miss || (in_acc && acc_done && viol_q);
  assign oe_no   = !(in_acc && !wr_q);
  assign addr_o  = off_q;

  for (genvar a = 0; a < N_AREAS; a++) begin : g_cs
    assign cs_no[a] = !(busy && (area_q == IDX_W'(a)));
  end

  for (genvar l = 0; l < LANES; l++) begin : g_we
    assign we_no[l] = !(in_acc && wr_q && !viol_q && be_q[l]);
  end
endmodule

// File: rtl/smc_top.sv
`timescale 1ns/1ps
module smc_top import smc_pkg::*; #(
  parameter int N_AREAS = 4,
  parameter int ADDR_W  = 32,
  parameter int SEL_W   = 3,
  parameter int LANES   = 2,
  parameter logic [ADDR_W-1:0] CFG_BASE = 32'hE000_8000,
  parameter logic [ADDR_W-1:0] SCR_ADDR = 32'hE000_2004
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_sel_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [CFG_W-1:0]    reg_wdata_i,
  output logic [CFG_W-1:0]    reg_rdata_o,
  input  logic                req_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  input  logic [LANES-1:0]    be_i,
  output logic                ready_o,
  output logic                err_o,
  output logic [N_AREAS-1:0]  mem_cs_no,
  output logic                mem_oe_no,
  output logic [LANES-1:0]    mem_we_no,
  output logic [ADDR_W-SEL_W-1:0] mem_addr_o,
  input  logic                ext_wait_ni
);
  localparam int IDX_W = (N_AREAS > 1) ? $clog2(N_AREAS) : 1;
  localparam int OFF_W = ADDR_W - SEL_W;

  logic [N_AREAS-1:0][WAIT_W-1:0] acc_wait_a, rec_wait_a;
  logic [N_AREAS-1:0]             wait_prog_a, rd_only_a, sub_wr_a;
  logic [N_AREAS-1:0][DSZ_W-1:0]  dsize_a;
  logic                           swap;
  logic                           dec_hit;
  logic [IDX_W-1:0]               dec_area;

  smc_cfg_regs #(
    .N_AREAS (N_AREAS),
    .ADDR_W  (ADDR_W),
    .CFG_BASE(CFG_BASE),
    .SCR_ADDR(SCR_ADDR)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_sel_i  (reg_sel_i),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .acc_wait_o (acc_wait_a),
    .rec_wait_o (rec_wait_a),
    .wait_prog_o(wait_prog_a),
    .rd_only_o  (rd_only_a),
    .sub_wr_o   (sub_wr_a),
    .dsize_o    (dsize_a),
    .swap_o     (swap)
  );

  smc_area_decode #(
    .N_AREAS(N_AREAS),
    .SEL_W  (SEL_W),
    .IDX_W  (IDX_W)
  ) u_dec (
    .sel_i (addr_i[ADDR_W-1 -: SEL_W]),
    .swap_i(swap),
    .hit_o (dec_hit),
    .area_o(dec_area)
  );

  smc_access_fsm #(
    .N_AREAS(N_AREAS),
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W),
    .LANES  (LANES)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .wr_i       (wr_i),
    .be_i       (be_i),
    .off_i      (addr_i[OFF_W-1:0]),
    .hit_i      (dec_hit),
    .area_i     (dec_area),
    .acc_wait_i (acc_wait_a[dec_area]),
    .rec_wait_i (rec_wait_a[dec_area]),
    .wait_prog_i(wait_prog_a[dec_area]),
    .rd_only_i  (rd_only_a[dec_area]),
    .sub_wr_i   (sub_wr_a[dec_area]),
    .dsize_i    (dsize_a[dec_area]),
    .ext_wait_ni(ext_wait_ni),
    .ready_o    (ready_o),
    .err_o      (err_o),
    .cs_no      (mem_cs_no),
    .oe_no      (mem_oe_no),
    .we_no      (mem_we_no),
    .addr_o     (mem_addr_o)
  );
endmodule

// File: rtl/smc_checker.sv
`timescale 1ns/1ps
module smc_checker #(
  parameter int N_AREAS = 4,
  parameter int LANES   = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_AREAS-1:0] mem_cs_no,
  input logic               mem_oe_no,
  input logic [LANES-1:0]   mem_we_no,
  input logic               ready_o,
  input logic               err_o
);
  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~mem_cs_no) <= 1); // R9

  AST_CS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_cs_no != '1) && ($past(mem_cs_no) != '1)) |-> (mem_cs_no == $past(mem_cs_no))); // R9

  AST_ERR_WITH_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ready_o); // R5

  AST_NO_STROBE_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (mem_we_no == '1)); // R6

  AST_OE_WE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && (mem_we_no != '1))); // R7

  AST_STROBE_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no || (mem_we_no != '1)) |-> (mem_cs_no != '1)); // R7
endmodule

bind smc_top smc_checker #(.N_AREAS(N_AREAS), .LANES(LANES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mem_cs_no(mem_cs_no),
  .mem_oe_no(mem_oe_no),
  .mem_we_no(mem_we_no),
  .ready_o  (ready_o),
  .err_o    (err_o)
);

// File: tb/smc_top_tb_top.sv
`timescale 1ns/1ps
module smc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_we = 1'b0;
  logic [31:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic        req = 1'b0, wr = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  be = '0;
  logic        ready, err, oe_n, ext_wait_n = 1'b1;
  logic [3:0]  cs_n;
  logic [1:0]  we_n;
  logic [28:0] maddr;

  always #4 clk = ~clk;

  smc_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_sel_i(reg_sel), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .req_i(req), .addr_i(addr), .wr_i(wr), .be_i(be),
    .ready_o(ready), .err_o(err),
    .mem_cs_no(cs_n), .mem_oe_no(oe_n), .mem_we_no(we_n),
    .mem_addr_o(maddr), .ext_wait_ni(ext_wait_n)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_sel = 1'b1; reg_we = 1'b1;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_sel = 1'b1; reg_we = 1'b0;
    #1 d = reg_rdata;
    reg_sel = 1'b0;
  endtask

  // results of the last access
  int         r_cyc, r_rdy;
  logic       r_err, r_oe;
  logic [3:0] r_cs;
  logic [1:0] r_we;

  // ext_k < 0: external wait held high; else low until the (ext_k+1)th access cycle
  task automatic run_acc(input logic [31:0] a, input logic w, input logic [1:0] b, input int ext_k);
    @(negedge clk);
    req = 1'b1; addr = a; wr = w; be = b;
    r_cyc = 0; r_rdy = -1; r_err = 1'b0; r_oe = 1'b0; r_cs = '0; r_we = '0;
    for (int c = 0; c < 300; c++) begin
      if (ext_k >= 0) ext_wait_n = (c >= 2 + ext_k);
      #1;
      if (cs_n != 4'hF) begin r_cyc++; r_cs |= ~cs_n; end
      r_we |= ~we_n;
      if (!oe_n) r_oe = 1'b1;
      if (ready && r_rdy < 0) begin
        r_rdy = c; r_err = err; req = 1'b0;
      end
      if (r_rdy >= 0 && cs_n == 4'hF) break;
      @(negedge clk);
    end
    req = 1'b0;
    ext_wait_n = 1'b1;
  endtask

  // {area[1:0], cfg[31:0], addr[31:0], wr, be[1:0], exp_cs[3:0], exp_we[1:0], exp_err}
  localparam int NV = 9;
  localparam logic [75:0] VEC [NV] = '{
    {2'd1, 32'h2300_0069, 32'h2000_0010, 1'b1, 2'b01, 4'b0010, 2'b01, 1'b0},
    {2'd1, 32'h2300_0069, 32'h2000_0020, 1'b0, 2'b11, 4'b0010, 2'b00, 1'b0},
    {2'd3, 32'h0000_006E, 32'h6000_0004, 1'b1, 2'b11, 4'b1000, 2'b11, 1'b0},
    {2'd0, 32'h1100_0035, 32'h0000_0100, 1'b1, 2'b11, 4'b0001, 2'b00, 1'b1},
    {2'd2, 32'h4200_0025, 32'h4000_0000, 1'b1, 2'b10, 4'b0100, 2'b00, 1'b1},
    {2'd2, 32'h4200_0025, 32'h4000_0002, 1'b1, 2'b11, 4'b0100, 2'b11, 1'b0},
    {2'd0, 32'h1100_0035, 32'h0000_0200, 1'b0, 2'b01, 4'b0001, 2'b00, 1'b0},
    {2'd3, 32'h0100_002E, 32'h6000_0010, 1'b1, 2'b10, 4'b1000, 2'b10, 1'b0},
    {2'd3, 32'h0000_0026, 32'h6000_0020, 1'b1, 2'b01, 4'b1000, 2'b00, 1'b1}
  };

  localparam logic [31:0] CFG0 = 32'hE000_8000;
  localparam logic [31:0] SCR  = 32'hE000_2004;

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [75:0] e;
    logic [31:0] d, cfg;
    int aw, sw;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    #1;
    chk("R1", "cs idle", cs_n, 4'hF);
    chk("R7", "oe/we idle", {oe_n, we_n}, 3'b111);
    chk("R3", "ready idle", ready, 1'b0);
    for (int i = 0; i < 4; i++) begin
      reg_read(CFG0 + 4 * i, d);
      chk("R2", "reset cfg", d, (i == 0) ? 32'hFF00_0035 : 32'hFF00_0034);
    end
    reg_read(SCR, d);
    chk("R8", "reset scr", d, 32'h0);

    // reset timing: 15 access + 15 recovery waits
    run_acc(32'h4000_0000, 1'b0, 2'b11, -1);
    chk("R3", "reset ready cycle", r_rdy, 17);
    chk("R3", "reset cs length", r_cyc, 32);
    run_acc(32'h6000_0000, 1'b1, 2'b11, -1);
    chk("R5", "reset area is read-only err", r_err, 1'b1);
    chk("R5", "reset area no strobe", r_we, 2'b00);

    // reserved bits
    reg_write(CFG0 + 4, 32'hFFFF_FFFF);
    reg_read(CFG0 + 4, d);
    chk("R2", "reserved read zero", d, 32'hFF00_00FF);

    // vector table
    for (int v = 0; v < NV; v++) begin
      e   = VEC[v];
      cfg = e[73:42];
      aw  = int'(cfg[31:28]);
      sw  = int'(cfg[27:24]);
      reg_write(CFG0 + 32'(4 * int'(e[75:74])), cfg);
      run_acc(e[41:10], e[9], e[8:7], -1);
      chk("R3", $sformatf("vec%0d ready cycle", v), r_rdy, aw + 2);
      chk("R3", $sformatf("vec%0d cs length", v), r_cyc, aw + sw + 2);
      chk("R1", $sformatf("vec%0d chip select", v), r_cs, e[6:3]);
      chk("R7", $sformatf("vec%0d strobes", v), r_we, e[2:1]);
      chk("R7", $sformatf("vec%0d output enable", v), r_oe, !e[9]);
      chk("R5 R6", $sformatf("vec%0d error", v), r_err, e[0]);
    end

    // external wait source
    reg_write(CFG0 + 4, 32'h0000_0049);
    run_acc(32'h2000_0000, 1'b0, 2'b11, 4);
    chk("R4", "ext wait ready cycle", r_rdy, 6);
    chk("R4", "ext wait cs length", r_cyc, 6);
    run_acc(32'h2000_0000, 1'b0, 2'b11, 0);
    chk("R4", "ext wait none ready", r_rdy, 2);
    // programmed mode ignores a held-low external wait
    reg_write(CFG0 + 4, 32'h1000_0069);
    run_acc(32'h2000_0000, 1'b0, 2'b11, 99);
    chk("R4", "prog ignores ext wait", r_rdy, 3);
    chk("R4", "prog ignores ext len", r_cyc, 3);

    // unmapped
    run_acc(32'hE000_0000, 1'b1, 2'b11, -1);
    chk("R1", "unmapped ready", r_rdy, 0);
    chk("R1", "unmapped err", r_err, 1'b1);
    chk("R1", "unmapped no cs", r_cs, 4'h0);
    run_acc(32'h8000_0000, 1'b0, 2'b11, -1);
    chk("R1", "unmapped 0x8 err", r_err, 1'b1);

    // swap
    reg_write(SCR, 32'hFFFF_FFFF);
    reg_read(SCR, d);
    chk("R8", "scr only bit0", d, 32'h1);
    reg_write(CFG0 + 12, 32'h0200_006E);
    reg_write(CFG0,      32'h3100_0035);
    run_acc(32'h0000_0040, 1'b0, 2'b11, -1);
    chk("R8", "swap zero -> area3 cs", r_cs, 4'b1000);
    chk("R8", "swap zero timing", r_cyc, 4);
    run_acc(32'h6000_0040, 1'b0, 2'b11, -1);
    chk("R8", "swap top -> area0 cs", r_cs, 4'b0001);
    chk("R8", "swap top timing", r_rdy, 5);

    // swap cleared mid-access
    reg_write(CFG0 + 12, 32'h5000_006E);
    fork
      run_acc(32'h0000_0000, 1'b0, 2'b11, -1);
      begin
        repeat (3) @(negedge clk);
        reg_write(SCR, 32'h0);
      end
    join
    chk("R9", "mid-access swap single cs", r_cs, 4'b1000);
    chk("R9", "mid-access swap timing", r_rdy, 7);
    run_acc(32'h0000_0000, 1'b0, 2'b11, -1);
    chk("R9", "swap off next access", r_cs, 4'b0001);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule